// File: doc/BRIEF.md
# Timer interrupt and trigger router

This block sits beside a timer's counting and capture logic. It keeps the timer's status flags and turns them into a CPU interrupt, a wake-up request and one-cycle trigger pulses for downstream consumers. The counting and capture datapaths are outside the block. Their results arrive as single-cycle pulses: a compare-match pulse and a capture-event pulse.

Software clears a status flag by raising the clear strobe with a 1 in that flag's bit position. The bit positions are: bit 0 for the compare flag, bit 1 for the capture flag (this also clears the overrun status), and bit 2 for the wake status.

Trigger consumer index 0 is the ADC, index 1 is the DAC and index 2 is the DMA engine. The number of consumers is a parameter. A single source-select bit decides whether the compare flag or the capture flag feeds all of the triggers. Each consumer has its own enable bit.

Top module: `tmr_irq_router`

## Requirements
- R1: A compare-match pulse sets the compare flag. `cmp_flag_o` reads 1 from the clock edge that samples the pulse.
- R2: A clear write with bit 0 set clears the compare flag at that edge. Writes with bit 0 at 0 leave the compare flag unchanged.
- R3: A capture-event pulse sets the capture flag only while `cap_en_i` is 1. A capture pulse with `cap_en_i` at 0 changes no flag and no output.
- R4: A clear write with bit 1 set clears the capture flag at that edge.
- R5: The interrupt is the OR of (compare flag AND `cmp_ie_i`) and (capture flag AND `cap_ie_i`). With `IRQ_REG`=0 `irq_o` follows this combination in the same cycle. With `IRQ_REG`=1 it follows one clock later.
- R6: With `trig_src_i`=0 the compare flag drives the triggers, and with `trig_src_i`=1 the capture flag drives them. `trig_o[i]` is 1 for exactly the first cycle in which the selected flag reads 1 after reading 0, and only if `trig_en_i[i]` is 1. Switching the source onto a flag that is already set gives no pulse.
- R7: `wake_req_o` is 1 whenever `wake_en_i` is 1 and either the compare flag or the capture flag is set.
- R8: The wake status sets at an edge where `wake_req_o` and `pwr_down_i` are both 1. It then stays set until a clear write with bit 2.
- R9: A qualified capture that arrives while the capture flag is already set sets the overrun status. The capture flag stays set. Clearing the capture flag (bit 1) clears the overrun status in the same edge. A capture that coincides with that clear counts as a fresh capture, so it does not set the overrun status.
- R10: When a hardware set and a software clear hit the compare flag, the capture flag or the wake status in the same cycle, the flag ends up set.
- R11: While reset is asserted all flags, `irq_o`, `wake_req_o` and `trig_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_evt_i | input | 1 | Compare-match pulse |
| cap_evt_i | input | 1 | Capture-event pulse |
| cap_en_i | input | 1 | Capture function enable |
| cmp_ie_i | input | 1 | Compare interrupt enable |
| cap_ie_i | input | 1 | Capture interrupt enable |
| trig_src_i | input | 1 | Trigger source: 0 compare flag, 1 capture flag |
| trig_en_i | input | NUM_TRIG | Per-consumer trigger enables (0 ADC, 1 DAC, 2 DMA) |
| wake_en_i | input | 1 | Wake-up request enable |
| pwr_down_i | input | 1 | System is in power-down |
| clr_we_i | input | 1 | Clear write strobe |
| clr_bits_i | input | 3 | Clear mask: bit 0 compare, bit 1 capture and overrun, bit 2 wake status |
| cmp_flag_o | output | 1 | Compare flag |
| cap_flag_o | output | 1 | Capture flag |
| ovr_flag_o | output | 1 | Capture overrun status |
| wake_sts_o | output | 1 | Sticky wake status |
| irq_o | output | 1 | CPU interrupt |
| wake_req_o | output | 1 | Wake-up request |
| trig_o | output | NUM_TRIG | One-cycle trigger pulses |

## Verification
The bench builds the block with `NUM_TRIG`=3 and `IRQ_REG`=1. This exercises the registered interrupt path and a separate enable for each of the three consumers. The default `IRQ_REG`=0 variant is covered only by elaboration and its in-line assertions.

The stimulus runs in phases with different event and clear densities, and it toggles the capture enable, the source select and the trigger enables. This makes simultaneous set-and-clear cycles, captures while the capture flag is pending, and source switches onto flags that are already set occur many times.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int CLR_W        = 3;
   localparam int CLR_CMP_BIT  = 0;
   localparam int CLR_CAP_BIT  = 1;
   localparam int CLR_WAKE_BIT = 2;
   localparam int NUM_SRC      = 2;

   typedef enum logic {
      SRC_CMP = 1'b0,
      SRC_CAP = 1'b1
   } trig_src_e;
endpackage

// File: rtl/tmr_w1c_flag.sv
module tmr_w1c_flag #(
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= RESET_VAL;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end

   assign q_o = q;

   // R10: a set wins over a clear in the same cycle
   a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> q_o);
   // R2, R4: a lone clear takes the flag down
   a_r2_clear_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !q_o);
   a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !set_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/tmr_cap_status.sv
module tmr_cap_status (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cap_evt_i,
   input  logic cap_en_i,
   input  logic clr_i,
   output logic flag_o,
   output logic ovr_o
);
   logic qual;
   logic flag;
   logic ovr;

   assign qual = cap_evt_i & cap_en_i;

   tmr_w1c_flag #(.RESET_VAL(1'b0)) i_cap_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (qual),
      .clr_i (clr_i),
      .q_o   (flag)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            ovr <= 1'b0;
      else if (clr_i)         ovr <= 1'b0;
      else if (qual && flag)  ovr <= 1'b1;
   end

   assign flag_o = flag;
   assign ovr_o  = ovr;

   // R9: capture while pending raises overrun
   a_r9_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (qual && flag && !clr_i) |=> ovr_o);
   a_r9_ovr_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !ovr_o);
   a_r9_ovr_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_o |-> flag_o);
   // R3: disabled capture leaves the flag alone
   a_r3_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o && !(cap_evt_i && cap_en_i)) |=> !flag_o);
endmodule

// File: rtl/tmr_trig_router.sv
module tmr_trig_router
   import tmr_irq_pkg::*;
#(
   parameter int NUM_TRIG = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cmp_flag_i,
   input  logic                cap_flag_i,
   input  logic                src_i,
   input  logic [NUM_TRIG-1:0] en_i,
   output logic [NUM_TRIG-1:0] trig_o
);
   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] prev;
   logic [NUM_SRC-1:0] rise;
   logic               sel_rise;
   trig_src_e          src;

   assign flags[SRC_CMP] = cmp_flag_i;
   assign flags[SRC_CAP] = cap_flag_i;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_edge
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) prev[s] <= 1'b0;
         else         prev[s] <= flags[s];
      end
      assign rise[s] = flags[s] & ~prev[s];

      // R6: a rise lasts one cycle
      a_r6_rise_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rise[s] |=> !rise[s]);
   end

   assign src      = trig_src_e'(src_i);
   assign sel_rise = (src == SRC_CAP) ? rise[SRC_CAP] : rise[SRC_CMP];

   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_out
      assign trig_o[g] = sel_rise & en_i[g];
   end

   // R6: any pulse needs the selected flag set
   a_r6_pulse_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|trig_o) |-> (src_i ? cap_flag_i : cmp_flag_i));
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
   import tmr_irq_pkg::*;
#(
   parameter int NUM_TRIG = 3,
   parameter int IRQ_REG  = 0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cmp_evt_i,
   input  logic                cap_evt_i,
   input  logic                cap_en_i,
   input  logic                cmp_ie_i,
   input  logic                cap_ie_i,
   input  logic                trig_src_i,
   input  logic [NUM_TRIG-1:0] trig_en_i,
   input  logic                wake_en_i,
   input  logic                pwr_down_i,
   input  logic                clr_we_i,
   input  logic [CLR_W-1:0]    clr_bits_i,
   output logic                cmp_flag_o,
   output logic                cap_flag_o,
   output logic                ovr_flag_o,
   output logic                wake_sts_o,
   output logic                irq_o,
   output logic                wake_req_o,
   output logic [NUM_TRIG-1:0] trig_o
);
   if (NUM_TRIG < 1 || NUM_TRIG > 32) begin : g_bad_trig
      $error("tmr_irq_router: NUM_TRIG must lie in 1..32");
   end
   if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
      $error("tmr_irq_router: IRQ_REG must be 0 or 1");
   end

   logic clr_cmp, clr_cap, clr_wake;
   logic cmp_flag, cap_flag, ovr_flag, wake_sts;
   logic wake_req, wake_set, irq_comb;

   assign clr_cmp  = clr_we_i & clr_bits_i[CLR_CMP_BIT];
   assign clr_cap  = clr_we_i & clr_bits_i[CLR_CAP_BIT];
   assign clr_wake = clr_we_i & clr_bits_i[CLR_WAKE_BIT];

   tmr_w1c_flag #(.RESET_VAL(1'b0)) i_cmp_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (cmp_evt_i),
      .clr_i (clr_cmp),
      .q_o   (cmp_flag)
   );

   tmr_cap_status i_cap_status (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cap_evt_i(cap_evt_i),
      .cap_en_i (cap_en_i),
      .clr_i    (clr_cap),
      .flag_o   (cap_flag),
      .ovr_o    (ovr_flag)
   );

   assign wake_req = wake_en_i & (cmp_flag | cap_flag);
   assign wake_set = wake_req & pwr_down_i;

   tmr_w1c_flag #(.RESET_VAL(1'b0)) i_wake_sts (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (wake_set),
      .clr_i (clr_wake),
      .q_o   (wake_sts)
   );

   tmr_trig_router #(.NUM_TRIG(NUM_TRIG)) i_trig (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmp_flag_i(cmp_flag),
      .cap_flag_i(cap_flag),
      .src_i     (trig_src_i),
      .en_i      (trig_en_i),
      .trig_o    (trig_o)
   );

   assign irq_comb = (cmp_flag & cmp_ie_i) | (cap_flag & cap_ie_i);

   if (IRQ_REG == 1) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= irq_comb;
      end
      assign irq_o = irq_q;

      // R5: registered interrupt follows one clock later
      a_r5_irq_lags: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ((cmp_flag_o && cmp_ie_i) || (cap_flag_o && cap_ie_i)) |=> irq_o);
   end else begin : g_irq_comb
      assign irq_o = irq_comb;

      // R5: interrupt needs a pending flag
      a_r5_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o |-> (cmp_flag_o || cap_flag_o));
   end

   assign cmp_flag_o = cmp_flag;
   assign cap_flag_o = cap_flag;
   assign ovr_flag_o = ovr_flag;
   assign wake_sts_o = wake_sts;
   assign wake_req_o = wake_req;

   // R8: wake status is sticky until its clear
   a_r8_wake_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_sts_o && !clr_wake) |=> wake_sts_o);
   // R7: no flag, no wake request
   a_r7_wake_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_req_o |-> (cmp_flag_o || cap_flag_o));
endmodule

// File: tb/test_tmr_irq_router.sv
`timescale 1ns/1ps
module test_tmr_irq_router;
   localparam int NT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp_evt = 0, cap_evt = 0, cap_en = 0, cmp_ie = 0, cap_ie = 0;
   logic src = 0, wake_en = 0, pd = 0, clr_we = 0;
   logic [NT-1:0] ten = '0;
   logic [2:0] clr_bits = '0;
   logic cmp_flag, cap_flag, ovr_flag, wake_sts, irq, wake_req;
   logic [NT-1:0] trig;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tmr_irq_router #(.NUM_TRIG(NT), .IRQ_REG(1)) i_tmr_irq_router (
      .clk_i(clk), .rst_ni(rst_n), .cmp_evt_i(cmp_evt), .cap_evt_i(cap_evt),
      .cap_en_i(cap_en), .cmp_ie_i(cmp_ie), .cap_ie_i(cap_ie),
      .trig_src_i(src), .trig_en_i(ten), .wake_en_i(wake_en),
      .pwr_down_i(pd), .clr_we_i(clr_we), .clr_bits_i(clr_bits),
      .cmp_flag_o(cmp_flag), .cap_flag_o(cap_flag), .ovr_flag_o(ovr_flag),
      .wake_sts_o(wake_sts), .irq_o(irq), .wake_req_o(wake_req), .trig_o(trig));

   // behavioural reference model
   bit m_cmp, m_cap, m_ovr, m_wake, m_pc, m_pp, m_irq;

   function automatic bit irq_now();
      return (m_cmp && cmp_ie) || (m_cap && cap_ie);
   endfunction
   function automatic bit wreq_now();
      return wake_en && (m_cmp || m_cap);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cmp <= 0; m_cap <= 0; m_ovr <= 0; m_wake <= 0;
         m_pc <= 0; m_pp <= 0; m_irq <= 0;
      end else begin
         bit capq, cclr;
         capq = cap_evt && cap_en;
         cclr = clr_we && clr_bits[1];
         m_cmp <= cmp_evt ? 1'b1 : ((clr_we && clr_bits[0]) ? 1'b0 : m_cmp);
         m_cap <= capq ? 1'b1 : (cclr ? 1'b0 : m_cap);
         m_ovr <= cclr ? 1'b0 : ((capq && m_cap) ? 1'b1 : m_ovr);
         m_wake <= (pd && wreq_now()) ? 1'b1 :
                   ((clr_we && clr_bits[2]) ? 1'b0 : m_wake);
         m_pc <= m_cmp;
         m_pp <= m_cap;
         m_irq <= irq_now();
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   task automatic check_all();
      bit rise_sel;
      logic [NT-1:0] etrig;
      rise_sel = src ? (m_cap && !m_pp) : (m_cmp && !m_pc);
      for (int i = 0; i < NT; i++) etrig[i] = rise_sel && ten[i];
      check("R1/R2/R10 compare flag", {31'd0, cmp_flag}, {31'd0, m_cmp});
      check("R3/R4/R10 capture flag", {31'd0, cap_flag}, {31'd0, m_cap});
      check("R9 overrun", {31'd0, ovr_flag}, {31'd0, m_ovr});
      check("R8/R10 wake status", {31'd0, wake_sts}, {31'd0, m_wake});
      check("R5 interrupt", {31'd0, irq}, {31'd0, m_irq});
      check("R7 wake request", {31'd0, wake_req}, {31'd0, wreq_now()});
      check("R6 triggers", {29'd0, trig}, {29'd0, etrig});
   endtask

   task automatic drive(int pev, int pclr, bit capoff);
      cmp_evt  = ($urandom_range(99) < pev);
      cap_evt  = ($urandom_range(99) < pev);
      clr_we   = ($urandom_range(99) < pclr);
      clr_bits = 3'($urandom_range(7));
      if ($urandom_range(99) < 8) cap_en = capoff ? 1'b0 : ~cap_en;
      if (capoff) cap_en = 1'b0;
      if ($urandom_range(99) < 10) src = ~src;
      if ($urandom_range(99) < 10) ten = NT'($urandom_range(7));
      if ($urandom_range(99) < 10) cmp_ie = ~cmp_ie;
      if ($urandom_range(99) < 10) cap_ie = ~cap_ie;
      if ($urandom_range(99) < 10) wake_en = ~wake_en;
      if ($urandom_range(99) < 15) pd = ~pd;
   endtask

   initial begin
      void'($urandom(32'h1d2c));
      // R11: reset state with events applied
      cmp_evt = 1; cap_evt = 1; cap_en = 1; wake_en = 1; ten = '1;
      repeat (3) @(negedge clk);
      check("R11 reset flags", {28'd0, cmp_flag, cap_flag, ovr_flag, wake_sts}, 32'd0);
      check("R11 reset outputs", {27'd0, irq, wake_req, trig}, 32'd0);
      cmp_evt = 0; cap_evt = 0; cap_en = 0; wake_en = 0; ten = '0;
      @(negedge clk);
      rst_n = 1;
      for (int ph = 0; ph < 6; ph++) begin
         for (int c = 0; c < 1500; c++) begin
            @(negedge clk);
            check_all();
            case (ph)
               0: drive(10, 10, 0);
               1: drive(40, 5, 0);
               2: drive(5, 60, 0);
               3: drive(30, 30, 1);   // R3: captures with capture disabled
               4: drive(50, 50, 0);   // R10: frequent set/clear collisions
               default: drive(20, 20, 0);
            endcase
         end
      end
      @(negedge clk);
      check_all();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule